// File: doc/BRIEF.md
# DMA channel request and enable controller

This block is the control side of one channel of a two-channel DMA engine. It holds the channel enable bit and a pending-request flag. It picks the trigger source, which is either a software request bit or one peripheral interrupt-request line chosen by a select field. When a request is pending on an enabled channel, it sends a one-cycle start strobe to the transfer datapath. It then waits for a completion acknowledge. That acknowledge steps the working address pointer and the transfer counter.

Software reaches the block through a small synchronous write port and an asynchronous read port. Every write that sets the enable bit re-initialises the working pointer and the counter from their setup registers. This happens even if the channel is already running. The request flag records triggers even while the channel is disabled. Software can only clear the flag. Changing the source selection counts as a trigger, so software has to clear the flag after it re-selects a source. When the counter runs out, the channel turns itself off and raises a single-cycle done pulse.

Top module: `dmach_ctrl`

## Requirements
- R1: A write to the control register (address 0) with bit 0 (enable) = 1 loads the working pointer. It loads from the source register (address 2) when bit 2 (source forward) of the written value is 1. It loads from the destination register (address 3) when bit 3 (destination forward) is 1 and bit 2 is 0. In any other case it loads from the source register. The same load happens again on every such write, even while the channel is already enabled.
- R2: The same enabling write loads the working counter from the reload register (address 4).
- R3: Any selected trigger sets the request flag (control bit 1), whether or not the channel is enabled.
- R4: A control write with bit 1 = 0 clears the request flag, and this clear wins over a trigger in the same cycle. A control write with bit 1 = 1 leaves the flag unchanged.
- R5: `xfer_start` is high for one cycle when all of these hold: enable = 1, flag = 1, no transfer is outstanding, and no control write is presented in that cycle. The flag clears at that clock edge. Only one transfer may be outstanding, and it stays outstanding until `xfer_ack`.
- R6: In software mode (select register, address 1, bit 5 = 0), a select write with bit 6 = 1 is a trigger.
- R7: In peripheral mode (select bit 5 = 1), a 0-to-1 change of `periph_irq[{sel[4], sel[3:0]}]` is a trigger. Each rise triggers exactly once. A held level does not trigger again, and lines that are not selected have no effect.
- R8: A select write whose bits 5:0 differ from the stored bits 5:0 is a trigger.
- R9: `xfer_ack` while a transfer is outstanding does two things. It decrements the counter. It increments the pointer when either forward bit is set. When the counter goes from 1 to 0, the enable bit clears and `done_pulse` is high for exactly the next cycle. `xfer_ack` with no transfer outstanding is ignored.
- R10: When an enabling control write and a completing `xfer_ack` fall in the same cycle, the reload wins. There is no decrement and no done pulse.
- R11: Reads return the following values. Address 0 gives {bit3 destination forward, bit2 source forward, bit1 flag, bit0 enable}. Address 1 gives select bits 5:0, and bit 6 reads as 0. Addresses 2, 3 and 4 give the source, destination and reload registers. Address 5 gives the pointer, address 6 gives the counter, and address 7 gives 0. All registers are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Register read data (combinational) |
| periph_irq | input | 2**(SELW+1) | Peripheral interrupt-request lines |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| xfer_ack | input | 1 | Transfer completed by the datapath |
| ptr_out | output | DW | Working address pointer |
| cnt_out | output | DW | Working transfer counter |
| done_pulse | output | 1 | Counter reached zero |

## Verification
The enabling control write can land in the same cycle as a pending start or a completing acknowledge. In that case the reload, the flag clear and the suppressed start must all win over the transfer side. Directed sequences raise a software trigger and then issue a control write exactly when the start would fire. They also present an acknowledge together with an enabling write. The random phase produces these collisions often, because writes and acknowledges are dense. A cycle model in the bench, built from the requirements, judges every cycle's start strobe, done pulse, pointer, counter and read data.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  // register addresses
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_SEL  = 3'd1;
  localparam logic [2:0] A_SRC  = 3'd2;
  localparam logic [2:0] A_DST  = 3'd3;
  localparam logic [2:0] A_REL  = 3'd4;
  localparam logic [2:0] A_PTR  = 3'd5;
  localparam logic [2:0] A_CNT  = 3'd6;

  // control register bit positions
  localparam int CB_EN   = 0;
  localparam int CB_REQ  = 1;
  localparam int CB_SFWD = 2;
  localparam int CB_DFWD = 3;
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int DW   = 16,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [2:0]      rd_addr,
  input  logic            en_q,
  input  logic            req_q,
  input  logic [DW-1:0]   ptr_q,
  input  logic [DW-1:0]   cnt_q,
  output logic [DW-1:0]   rd_data,
  output logic            ctrl_wr,
  output logic            wd_en,
  output logic            wd_req,
  output logic            wd_sfwd,
  output logic            wd_dfwd,
  output logic            sfwd_q,
  output logic            dfwd_q,
  output logic            sel_wr,
  output logic [SELW+2:0] sel_wd,
  output logic [SELW+1:0] sel_q,
  output logic [DW-1:0]   src_q,
  output logic [DW-1:0]   dst_q,
  output logic [DW-1:0]   rel_q
);
  logic src_wr, dst_wr, rel_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign sel_wr  = wr_en && (wr_addr == A_SEL);
  assign src_wr  = wr_en && (wr_addr == A_SRC);
  assign dst_wr  = wr_en && (wr_addr == A_DST);
  assign rel_wr  = wr_en && (wr_addr == A_REL);

  assign wd_en   = wr_data[CB_EN];
  assign wd_req  = wr_data[CB_REQ];
  assign wd_sfwd = wr_data[CB_SFWD];
  assign wd_dfwd = wr_data[CB_DFWD];
  assign sel_wd  = wr_data[SELW+2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfwd_q <= 1'b0;
      dfwd_q <= 1'b0;
      sel_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      rel_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        sfwd_q <= wd_sfwd;
        dfwd_q <= wd_dfwd;
      end
      if (sel_wr) sel_q <= sel_wd[SELW+1:0];
      if (src_wr) src_q <= wr_data;
      if (dst_wr) dst_q <= wr_data;
      if (rel_wr) rel_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[CB_EN]   = en_q;
        rd_data[CB_REQ]  = req_q;
        rd_data[CB_SFWD] = sfwd_q;
        rd_data[CB_DFWD] = dfwd_q;
      end
      A_SEL:   rd_data[SELW+1:0] = sel_q;
      A_SRC:   rd_data = src_q;
      A_DST:   rd_data = dst_q;
      A_REL:   rd_data = rel_q;
      A_PTR:   rd_data = ptr_q;
      A_CNT:   rd_data = cnt_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dmach_trigger.sv
module dmach_trigger #(
  parameter int SELW = 4,
  localparam int NSRC = 2**(SELW+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW+1:0] sel_q,
  input  logic            sel_wr,
  input  logic [SELW+2:0] sel_wd,
  input  logic [NSRC-1:0] irq,
  output logic            trig
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] rise;
  logic            hw_mode;
  logic            hw_edge;
  logic            sw_hit;
  logic            sel_chg;

  for (genvar g = 0; g < NSRC; g++) begin : g_edge
    assign rise[g] = irq[g] & ~prev_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq;
  end

  assign hw_mode = sel_q[SELW+1];
  assign hw_edge = hw_mode & rise[sel_q[SELW:0]];
  assign sw_hit  = sel_wr & sel_wd[SELW+2] & ~sel_wd[SELW+1];
  assign sel_chg = sel_wr & (sel_wd[SELW+1:0] != sel_q);
  assign trig    = hw_edge | sw_hit | sel_chg;
endmodule

// File: rtl/dmach_xfer.sv
module dmach_xfer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          wd_en,
  input  logic          wd_req,
  input  logic          wd_sfwd,
  input  logic          wd_dfwd,
  input  logic          sfwd_q,
  input  logic          dfwd_q,
  input  logic [DW-1:0] src_q,
  input  logic [DW-1:0] dst_q,
  input  logic [DW-1:0] rel_q,
  input  logic          trig,
  input  logic          xfer_ack,
  output logic          xfer_start,
  output logic          done_pulse,
  output logic          en_q,
  output logic          req_q,
  output logic          busy_q,
  output logic [DW-1:0] ptr_q,
  output logic [DW-1:0] cnt_q,
  output logic          reload,
  output logic          fire,
  output logic          sw_clr
);
  function automatic logic [DW-1:0] load_ptr(input logic [DW-1:0] s, input logic [DW-1:0] d,
                                             input logic sf, input logic df);
    return (df && !sf) ? d : s;
  endfunction

  function automatic logic [DW-1:0] step_ptr(input logic [DW-1:0] p, input logic fwd);
    return fwd ? p + 1'b1 : p;
  endfunction

  function automatic logic last_beat(input logic [DW-1:0] c);
    return c == {{(DW-1){1'b0}}, 1'b1};
  endfunction

  logic finish;

  assign reload     = ctrl_wr & wd_en;
  assign sw_clr     = ctrl_wr & ~wd_req;
  assign fire       = xfer_ack & busy_q;
  assign finish     = fire & ~reload & last_beat(cnt_q);
  assign xfer_start = en_q & req_q & ~busy_q & ~ctrl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      req_q      <= 1'b0;
      busy_q     <= 1'b0;
      ptr_q      <= '0;
      cnt_q      <= '0;
      done_pulse <= 1'b0;
    end else begin
      if (ctrl_wr)     en_q <= wd_en;
      else if (finish) en_q <= 1'b0;

      if (sw_clr)          req_q <= 1'b0;
      else if (trig)       req_q <= 1'b1;
      else if (xfer_start) req_q <= 1'b0;

      busy_q <= xfer_start | (busy_q & ~xfer_ack);

      if (reload) begin
        ptr_q <= load_ptr(src_q, dst_q, wd_sfwd, wd_dfwd);
        cnt_q <= rel_q;
      end else if (fire) begin
        ptr_q <= step_ptr(ptr_q, sfwd_q | dfwd_q);
        cnt_q <= cnt_q - 1'b1;
      end

      done_pulse <= finish;
    end
  end
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl #(
  parameter int DW   = 16,
  parameter int SELW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2:0]             wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [2:0]             rd_addr,
  output logic [DW-1:0]          rd_data,
  input  logic [2**(SELW+1)-1:0] periph_irq,
  output logic                   xfer_start,
  input  logic                   xfer_ack,
  output logic [DW-1:0]          ptr_out,
  output logic [DW-1:0]          cnt_out,
  output logic                   done_pulse
);
  logic            ctrl_wr, wd_en, wd_req, wd_sfwd, wd_dfwd;
  logic            sfwd_q, dfwd_q, sel_wr;
  logic [SELW+2:0] sel_wd;
  logic [SELW+1:0] sel_q;
  logic [DW-1:0]   src_q, dst_q, rel_q;
  logic            en_q, req_q, busy_q;
  logic            trig, reload, fire, sw_clr;

  dmach_regs #(.DW(DW), .SELW(SELW)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .en_q(en_q), .req_q(req_q), .ptr_q(ptr_out), .cnt_q(cnt_out),
    .rd_data(rd_data), .ctrl_wr(ctrl_wr), .wd_en(wd_en), .wd_req(wd_req),
    .wd_sfwd(wd_sfwd), .wd_dfwd(wd_dfwd), .sfwd_q(sfwd_q), .dfwd_q(dfwd_q),
    .sel_wr(sel_wr), .sel_wd(sel_wd), .sel_q(sel_q), .src_q(src_q), .dst_q(dst_q),
    .rel_q(rel_q)
  );

  dmach_trigger #(.SELW(SELW)) i_trig (
    .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .sel_wr(sel_wr), .sel_wd(sel_wd),
    .irq(periph_irq), .trig(trig)
  );

  dmach_xfer #(.DW(DW)) i_xfer (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wd_en(wd_en), .wd_req(wd_req),
    .wd_sfwd(wd_sfwd), .wd_dfwd(wd_dfwd), .sfwd_q(sfwd_q), .dfwd_q(dfwd_q),
    .src_q(src_q), .dst_q(dst_q), .rel_q(rel_q), .trig(trig), .xfer_ack(xfer_ack),
    .xfer_start(xfer_start), .done_pulse(done_pulse), .en_q(en_q), .req_q(req_q),
    .busy_q(busy_q), .ptr_q(ptr_out), .cnt_q(cnt_out), .reload(reload), .fire(fire),
    .sw_clr(sw_clr)
  );
endmodule

// File: rtl/dmach_ctrl_chk.sv
module dmach_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_start,
  input logic          xfer_ack,
  input logic          done_pulse,
  input logic          en_q,
  input logic          req_q,
  input logic          busy_q,
  input logic          trig,
  input logic          sw_clr,
  input logic          reload,
  input logic [DW-1:0] rel_q,
  input logic [DW-1:0] cnt_out
);
  AST_RELOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_out == $past(rel_q)); // R2

  AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !sw_clr) |=> req_q); // R3

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> !req_q); // R4

  AST_START_TAKES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !trig) |=> (busy_q && !req_q)); // R5

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !xfer_start); // R5

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (cnt_out == '0 && !en_q)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R9

  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && !busy_q && !reload) |=> $stable(cnt_out)); // R9
endmodule

bind dmach_ctrl dmach_ctrl_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_ack(xfer_ack),
  .done_pulse(done_pulse), .en_q(en_q), .req_q(req_q), .busy_q(busy_q),
  .trig(trig), .sw_clr(sw_clr), .reload(reload), .rel_q(rel_q), .cnt_out(cnt_out)
);

// File: tb/test_dmach_ctrl.sv
`timescale 1ns/1ps
module test_dmach_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [31:0] periph_irq = '0;
  logic        xfer_start;
  logic        xfer_ack = 1'b0;
  logic [15:0] ptr_out, cnt_out;
  logic        done_pulse;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dmach_ctrl i_dmach_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .periph_irq(periph_irq),
    .xfer_start(xfer_start), .xfer_ack(xfer_ack), .ptr_out(ptr_out),
    .cnt_out(cnt_out), .done_pulse(done_pulse)
  );

  // bench model state
  logic        m_en, m_req, m_busy, m_sf, m_df, m_done;
  logic [5:0]  m_sel;
  logic [15:0] m_src, m_dst, m_rel, m_ptr, m_cnt;
  logic [31:0] m_prev;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [15:0] rd_model(input logic [2:0] a);
    case (a)
      3'd0: return {12'b0, m_df, m_sf, m_req, m_en};
      3'd1: return {10'b0, m_sel};
      3'd2: return m_src;
      3'd3: return m_dst;
      3'd4: return m_rel;
      3'd5: return m_ptr;
      3'd6: return m_cnt;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic model_start(input logic we, input logic [2:0] wa);
    return m_en & m_req & ~m_busy & ~(we && wa == 3'd0);
  endfunction

  task automatic model_reset();
    m_en = 0; m_req = 0; m_busy = 0; m_sf = 0; m_df = 0; m_done = 0;
    m_sel = '0; m_src = '0; m_dst = '0; m_rel = '0; m_ptr = '0; m_cnt = '0; m_prev = '0;
  endtask

  // one clock: drive, judge, advance model, return idle at the falling edge
  task automatic step(input logic we, input logic [2:0] wa, input logic [15:0] wd,
                      input logic ack, input logic [2:0] ra);
    logic es, cw, sw, reload, fire, clr, hwe, trg, fin;
    logic [4:0] idx;
    wr_en = we; wr_addr = wa; wr_data = wd; xfer_ack = ack; rd_addr = ra;
    #1;
    es = model_start(we, wa);
    chk("R5 start", {15'b0, xfer_start}, {15'b0, es});
    chk("R9 done", {15'b0, done_pulse}, {15'b0, m_done});
    chk("R1 ptr", ptr_out, m_ptr);
    chk("R2 cnt", cnt_out, m_cnt);
    chk("R11 read", rd_data, rd_model(ra));
    @(posedge clk);
    cw = we && wa == 3'd0;
    sw = we && wa == 3'd1;
    reload = cw & wd[0];
    fire = ack & m_busy;
    clr = cw & ~wd[1];
    idx = m_sel[4:0];
    hwe = m_sel[5] & periph_irq[idx] & ~m_prev[idx];
    trg = (sw && wd[5:0] != m_sel) | (sw & wd[6] & ~wd[5]) | hwe;
    fin = fire & ~reload & (m_cnt == 16'd1);
    if (clr) m_req = 0; else if (trg) m_req = 1; else if (es) m_req = 0;
    m_busy = es | (m_busy & ~ack);
    m_done = fin;
    if (cw) m_en = wd[0]; else if (fin) m_en = 0;
    if (reload) begin
      m_ptr = (wd[3] && !wd[2]) ? m_dst : m_src;
      m_cnt = m_rel;
    end else if (fire) begin
      m_ptr = (m_sf | m_df) ? m_ptr + 16'd1 : m_ptr;
      m_cnt = m_cnt - 16'd1;
    end
    if (cw) begin m_sf = wd[2]; m_df = wd[3]; end
    if (sw) m_sel = wd[5:0];
    if (we && wa == 3'd2) m_src = wd;
    if (we && wa == 3'd3) m_dst = wd;
    if (we && wa == 3'd4) m_rel = wd;
    m_prev = periph_irq;
    @(negedge clk);
    wr_en = 0; xfer_ack = 0;
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0, 3'd0);
  endtask

  task automatic idle(input logic [2:0] ra);
    step(1'b0, 3'd0, 16'h0, 1'b0, ra);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    for (int a = 0; a < 8; a++) begin
      idle(3'(a));
      chk("R11 reset", rd_data, 16'h0);
    end
    wr(3'd2, 16'h1000);
    wr(3'd3, 16'h2000);
    wr(3'd4, 16'd3);
    // R3 software trigger while disabled
    wr(3'd1, 16'h0040);
    chk("R3 flag while disabled", rd_data[1], 1'b1);
    chk("R6 sw trigger no start when disabled", {15'b0, xfer_start}, 16'h0);
    // R4 write of 1 keeps, write of 0 clears
    wr(3'd0, 16'h0002);
    chk("R4 write one keeps", rd_data[1], 1'b1);
    wr(3'd0, 16'h0000);
    chk("R4 write zero clears", rd_data[1], 1'b0);
    // R1 / R2 enable loads
    wr(3'd0, 16'h0005);
    chk("R1 load from src", ptr_out, 16'h1000);
    chk("R2 load count", cnt_out, 16'd3);
    wr(3'd0, 16'h0009);
    chk("R1 reload from dst while enabled", ptr_out, 16'h2000);
    // R6 / R5 software request and start
    wr(3'd1, 16'h0040);
    chk("R6 flag set", rd_data[1], 1'b1);
    chk("R5 start one cycle after flag", {15'b0, xfer_start}, 16'h1);
    idle(3'd0);
    chk("R5 flag cleared by start", rd_data[1], 1'b0);
    chk("R5 no second start", {15'b0, xfer_start}, 16'h0);
    step(1'b0, 3'd0, 16'h0, 1'b1, 3'd0);
    chk("R9 count step", cnt_out, 16'd2);
    chk("R9 pointer step", ptr_out, 16'h2001);
    step(1'b0, 3'd0, 16'h0, 1'b1, 3'd0);
    chk("R9 idle ack ignored", cnt_out, 16'd2);
    // R10 ack together with enabling write
    wr(3'd1, 16'h0040);
    idle(3'd0);
    step(1'b1, 3'd0, 16'h0005, 1'b1, 3'd0);
    chk("R10 reload beats ack count", cnt_out, 16'd3);
    chk("R10 reload beats ack ptr", ptr_out, 16'h1000);
    // R4 clear with enable write in the start cycle
    wr(3'd1, 16'h0040);
    wr(3'd0, 16'h0005);
    chk("R4 clear wins over pending start", rd_data[1], 1'b0);
    chk("R10 start suppressed", {15'b0, xfer_start}, 16'h0);
    // R8 select change
    wr(3'd0, 16'h0004);
    wr(3'd1, 16'h0035);
    chk("R8 select change sets flag", rd_data[1], 1'b1);
    idle(3'd1);
    chk("R11 select readback", rd_data, 16'h0035);
    wr(3'd0, 16'h0004);
    // R7 peripheral edge on line 21
    periph_irq = 32'h1 << 21;
    idle(3'd0);
    chk("R7 rising edge sets flag", rd_data[1], 1'b1);
    wr(3'd0, 16'h0004);
    repeat (3) idle(3'd0);
    chk("R7 held level no retrigger", rd_data[1], 1'b0);
    periph_irq = periph_irq | (32'h1 << 3);
    idle(3'd0);
    chk("R7 unselected line ignored", rd_data[1], 1'b0);
    // R9 done at end of count
    wr(3'd4, 16'd2);
    wr(3'd0, 16'h0005);
    for (int k = 0; k < 2; k++) begin
      periph_irq = 32'h0;
      idle(3'd0);
      periph_irq = 32'h1 << 21;
      idle(3'd0);
      idle(3'd0);
      step(1'b0, 3'd0, 16'h0, 1'b1, 3'd0);
    end
    chk("R9 done pulse", {15'b0, done_pulse}, 16'h1);
    chk("R9 count at zero", cnt_out, 16'h0);
    chk("R9 enable cleared", rd_data[0], 1'b0);
    idle(3'd0);
    chk("R9 done one cycle", {15'b0, done_pulse}, 16'h0);
    // random phase, judged by the model each cycle
    for (int n = 0; n < 4000; n++) begin
      logic we, ack;
      logic [2:0] wa;
      logic [15:0] wd;
      int r;
      r = $urandom % 100;
      we = r < 35;
      wa = 3'($urandom % 6);
      wd = 16'($urandom);
      if (wa == 3'd1 && ($urandom % 10) < 6) wd[5:0] = m_sel;
      if (wa == 3'd4) wd = 16'(1 + $urandom % 4);
      if (($urandom % 10) < 3) periph_irq[$urandom % 32] ^= 1'b1;
      if (($urandom % 10) < 2) periph_irq[m_sel[4:0]] ^= 1'b1;
      ack = ($urandom % 10) < 4;
      step(we, wa, wd, ack, 3'($urandom % 8));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule